// File: doc/BRIEF.md
# Multi-Cycle CPU Bus Sequencer

This block paces a small 8-bit accumulator processor through its instructions. It splits each instruction into machine cycles and each machine cycle into clock states. Each machine cycle puts exactly one address on a shared memory and peripheral bus. So an instruction that touches the bus N times takes N machine cycles. Every instruction opens with an opcode fetch. The block decodes the opcode and then plans the remaining cycles. These can be memory reads for operands, memory writes, or a port transfer.

The block holds the program counter, the instruction register, a temporary byte, the W:Z address pair and the accumulator. The H and L bytes, and the register selected by an add-register opcode, live outside the block. The block reads them through plain inputs. On every clock it reports the current machine-cycle type and state number, along with the address, the write data and the strobes. It supports five operations:

- add a register to the accumulator;
- add a byte from the memory location held in H:L;
- store H:L at a direct address;
- read from a port;
- write to a port.

Top module: `cpu_bus_seq`

## Requirements
- R1: A synchronous active-high reset clears the program counter to RESET_PC (default 0) and clears the accumulator. On the first clock after reset, the block shows a FETCH cycle in state 1 with the address equal to RESET_PC and `insn_end` low.
- R2: Every state lasts one clock. `t_state` counts 1, 2, ... up to the state count of the current cycle and then returns to 1. `cyc_type` uses these codes: FETCH=0, MEMORY READ=1, MEMORY WRITE=2, INPUT=3, OUTPUT=4.
- R3: Every instruction begins with a 4-state FETCH whose address is the program counter. The opcode is taken from `bus_rdata` on the edge that ends state 3, and the program counter then increments. In state 4 the address shows the incremented counter.
- R4: An opcode of the form 10000sss with sss not equal to 110 finishes in that single FETCH (4 states). During state 4, `src_sel` equals sss. The accumulator becomes accumulator + `src_data`, modulo 256, on the edge that ends state 4.
- R5: Opcode 0x86 takes 7 states: FETCH, then a 3-state MEMORY READ at address {`reg_h`,`reg_l`}. The byte read becomes the temporary value. The accumulator becomes accumulator + that byte on the edge that ends state 7.
- R6: Opcode 0x22 takes 16 states. Two 3-state MEMORY READs at the program counter load Z and then W, and each advances the counter. A MEMORY WRITE of `reg_l` then goes to {W,Z}. The pair then increments with 16-bit wrap. A final MEMORY WRITE of `reg_h` goes to the new {W,Z}.
- R7: Opcode 0xDB takes 10 states: FETCH, a MEMORY READ of the port number p at the program counter, then a 3-state INPUT cycle at address {p,p}. The accumulator takes `bus_rdata` on the edge that ends that cycle's state 3.
- R8: Opcode 0xD3 takes 10 states: FETCH, a MEMORY READ of p, then a 3-state OUTPUT cycle at address {p,p} with `bus_wdata` equal to the accumulator.
- R9: `wr_stb` is high only in state 2 of MEMORY WRITE and OUTPUT cycles. `rd_stb` is high only in states 2 and 3 of FETCH, MEMORY READ and INPUT cycles. The two strobes are never high together.
- R10: The address holds steady across states 1 to 3 of every machine cycle, so each machine cycle carries one address.
- R11: Any other opcode executes as a 4-state FETCH only. It leaves the accumulator unchanged and advances the program counter by one.
- R12: `insn_end` is high exactly in the final state of each instruction. The next clock starts a FETCH in state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rdata | input | 8 | Read data from memory or a port, held stable while the address is steady |
| reg_h | input | 8 | Current H byte |
| reg_l | input | 8 | Current L byte |
| src_data | input | 8 | Value of the register that `src_sel` selects |
| src_sel | output | 3 | Source register index taken from the opcode's low bits |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data for MEMORY WRITE and OUTPUT cycles |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| cyc_type | output | 3 | Machine-cycle type code |
| t_state | output | 3 | State number within the machine cycle, 1 to 5 |
| insn_end | output | 1 | High in the last state of an instruction |
| acc_q | output | 8 | Accumulator |

## Verification
Some properties are checked on every clock. These are the state stepping and its range, the return to a state-1 FETCH after each instruction end, strobe placement and exclusion, address stability over states 1 to 3, the mirrored port address and the post-reset state. Other behaviour only the bench's instruction streams can show. That includes per-opcode cycle sequences and lengths, operand bytes landing in W and Z, the W:Z increment across a byte boundary, accumulator arithmetic with wrap, and the treatment of unsupported opcodes. The bench runs a reference model over directed corners and a seeded random program.

// File: rtl/cpuseq_pkg.sv
package cpuseq_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;
    localparam int TW = 3;
    localparam int MW = 3;

    typedef enum logic [2:0] {
        CY_FETCH  = 3'd0,
        CY_MREAD  = 3'd1,
        CY_MWRITE = 3'd2,
        CY_INPUT  = 3'd3,
        CY_OUTPUT = 3'd4
    } cyc_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ADD_REG,
        OP_ADD_MEM,
        OP_STORE_HL,
        OP_PORT_IN,
        OP_PORT_OUT
    } op_e;

    typedef struct packed {
        cyc_e          kind;
        logic [TW-1:0] n_states;
        logic          last;
    } mc_plan_t;

    localparam logic [DW-1:0] OPC_ADD_MEM  = 8'h86;
    localparam logic [DW-1:0] OPC_STORE_HL = 8'h22;
    localparam logic [DW-1:0] OPC_PORT_IN  = 8'hDB;
    localparam logic [DW-1:0] OPC_PORT_OUT = 8'hD3;
    localparam logic [4:0]    OPC_ADD_GRP  = 5'b10000;

    localparam logic [TW-1:0] FETCH_STATES = 3'd4;
    localparam logic [TW-1:0] XFER_STATES  = 3'd3;

    function automatic op_e classify(input logic [DW-1:0] ir);
        op_e r;
        if (ir == OPC_ADD_MEM)              r = OP_ADD_MEM;
        else if (ir[7:3] == OPC_ADD_GRP)    r = OP_ADD_REG;
        else if (ir == OPC_STORE_HL)        r = OP_STORE_HL;
        else if (ir == OPC_PORT_IN)         r = OP_PORT_IN;
        else if (ir == OPC_PORT_OUT)        r = OP_PORT_OUT;
        else                                r = OP_IDLE;
        return r;
    endfunction

    function automatic mc_plan_t plan_cycle(input op_e op, input logic [MW-1:0] mc);
        mc_plan_t p;
        p.kind     = CY_FETCH;
        p.n_states = FETCH_STATES;
        p.last     = 1'b1;
        if (mc == '0) begin
            p.last = (op == OP_IDLE) || (op == OP_ADD_REG);
        end else begin
            p.n_states = XFER_STATES;
            unique case (op)
                OP_ADD_MEM: begin
                    p.kind = CY_MREAD;
                    p.last = 1'b1;
                end
                OP_STORE_HL: begin
                    p.kind = (mc <= 3'd2) ? CY_MREAD : CY_MWRITE;
                    p.last = (mc == 3'd4);
                end
                OP_PORT_IN: begin
                    p.kind = (mc == 3'd1) ? CY_MREAD : CY_INPUT;
                    p.last = (mc == 3'd2);
                end
                OP_PORT_OUT: begin
                    p.kind = (mc == 3'd1) ? CY_MREAD : CY_OUTPUT;
                    p.last = (mc == 3'd2);
                end
                default: begin
                    p.n_states = FETCH_STATES;
                    p.last     = 1'b1;
                end
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/cpuseq_decode.sv
module cpuseq_decode
    import cpuseq_pkg::*;
(
    input  logic [DW-1:0] ir,
    input  logic [MW-1:0] mc_idx,
    output op_e           op,
    output mc_plan_t      plan
);
    always_comb begin
        op   = classify(ir);
        plan = plan_cycle(op, mc_idx);
    end
endmodule

// File: rtl/cpuseq_timing.sv
module cpuseq_timing
    import cpuseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] n_states,
    input  logic          last_mc,
    output logic [TW-1:0] t_state,
    output logic [MW-1:0] mc_idx,
    output logic          insn_end
);
    logic cyc_end;

    assign cyc_end  = (t_state == n_states);
    assign insn_end = cyc_end && last_mc;

    always_ff @(posedge clk) begin
        if (rst) begin
            t_state <= 3'd1;
            mc_idx  <= '0;
        end else if (cyc_end) begin
            t_state <= 3'd1;
            mc_idx  <= last_mc ? '0 : mc_idx + 3'd1;
        end else begin
            t_state <= t_state + 3'd1;
        end
    end
endmodule

// File: rtl/cpuseq_regs.sv
module cpuseq_regs
    import cpuseq_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  cyc_e          kind,
    input  op_e           op,
    input  logic [MW-1:0] mc_idx,
    input  logic [TW-1:0] t_state,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] src_data,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] ir,
    output logic [AW-1:0] wz,
    output logic [DW-1:0] acc
);
    logic [DW-1:0] tmp;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= RESET_PC;
            ir  <= '0;
            wz  <= '0;
            acc <= '0;
            tmp <= '0;
        end else begin
            unique case (kind)
                CY_FETCH: begin
                    if (t_state == 3'd3) begin
                        ir <= rdata;
                        pc <= pc + 16'd1;
                    end else if (t_state == 3'd4 && op == OP_ADD_REG) begin
                        acc <= acc + src_data;
                    end
                end
                CY_MREAD: begin
                    if (op == OP_ADD_MEM) begin
                        if (t_state == 3'd2) tmp <= rdata;
                        if (t_state == 3'd3) acc <= acc + tmp;
                    end else if (t_state == 3'd3) begin
                        pc <= pc + 16'd1;
                        if (mc_idx == 3'd1) wz[DW-1:0]  <= rdata;
                        else                wz[AW-1:DW] <= rdata;
                    end
                end
                CY_MWRITE: begin
                    if (t_state == 3'd3 && mc_idx == 3'd3) wz <= wz + 16'd1;
                end
                CY_INPUT: begin
                    if (t_state == 3'd3) acc <= rdata;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cpuseq_bus.sv
module cpuseq_bus
    import cpuseq_pkg::*;
(
    input  cyc_e          kind,
    input  op_e           op,
    input  logic [MW-1:0] mc_idx,
    input  logic [TW-1:0] t_state,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] wz,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] reg_h,
    input  logic [DW-1:0] reg_l,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          rd_stb,
    output logic          wr_stb
);
    logic rd_kind, wr_kind;

    always_comb begin
        addr  = pc;
        wdata = '0;
        unique case (kind)
            CY_FETCH:  addr = pc;
            CY_MREAD:  addr = (op == OP_ADD_MEM) ? {reg_h, reg_l} : pc;
            CY_MWRITE: begin
                addr  = wz;
                wdata = (mc_idx == 3'd3) ? reg_l : reg_h;
            end
            CY_INPUT:  addr = {wz[DW-1:0], wz[DW-1:0]};
            CY_OUTPUT: begin
                addr  = {wz[DW-1:0], wz[DW-1:0]};
                wdata = acc;
            end
            default: ;
        endcase
    end

    assign rd_kind = (kind == CY_FETCH) || (kind == CY_MREAD) || (kind == CY_INPUT);
    assign wr_kind = (kind == CY_MWRITE) || (kind == CY_OUTPUT);
    assign rd_stb  = rd_kind && (t_state == 3'd2 || t_state == 3'd3);
    assign wr_stb  = wr_kind && (t_state == 3'd2);
endmodule

// File: rtl/cpu_bus_seq.sv
module cpu_bus_seq
    import cpuseq_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_rdata,
    input  logic [7:0]  reg_h,
    input  logic [7:0]  reg_l,
    input  logic [7:0]  src_data,
    output logic [2:0]  src_sel,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic        rd_stb,
    output logic        wr_stb,
    output logic [2:0]  cyc_type,
    output logic [2:0]  t_state,
    output logic        insn_end,
    output logic [7:0]  acc_q
);
    logic [DW-1:0] ir;
    logic [AW-1:0] pc, wz;
    logic [MW-1:0] mc_idx;
    op_e           op;
    mc_plan_t      plan;

    cpuseq_decode u_dec (
        .ir     (ir),
        .mc_idx (mc_idx),
        .op     (op),
        .plan   (plan)
    );

    cpuseq_timing u_tim (
        .clk      (clk),
        .rst      (rst),
        .n_states (plan.n_states),
        .last_mc  (plan.last),
        .t_state  (t_state),
        .mc_idx   (mc_idx),
        .insn_end (insn_end)
    );

    cpuseq_regs #(.RESET_PC(RESET_PC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .kind     (plan.kind),
        .op       (op),
        .mc_idx   (mc_idx),
        .t_state  (t_state),
        .rdata    (bus_rdata),
        .src_data (src_data),
        .pc       (pc),
        .ir       (ir),
        .wz       (wz),
        .acc      (acc_q)
    );

    cpuseq_bus u_bus (
        .kind    (plan.kind),
        .op      (op),
        .mc_idx  (mc_idx),
        .t_state (t_state),
        .pc      (pc),
        .wz      (wz),
        .acc     (acc_q),
        .reg_h   (reg_h),
        .reg_l   (reg_l),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb)
    );

    assign cyc_type = plan.kind;
    assign src_sel  = ir[2:0];
endmodule

// File: rtl/cpu_bus_seq_chk.sv
module cpu_bus_seq_chk #(
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  cyc_type,
    input logic [2:0]  t_state,
    input logic [15:0] bus_addr,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic        insn_end
);
    localparam logic [2:0] K_FETCH = 3'd0;
    localparam logic [2:0] K_MRD   = 3'd1;
    localparam logic [2:0] K_MWR   = 3'd2;
    localparam logic [2:0] K_IN    = 3'd3;
    localparam logic [2:0] K_OUT   = 3'd4;

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (t_state == 3'd1 && cyc_type == K_FETCH && bus_addr == RESET_PC && !insn_end)); // R1
    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst) (t_state >= 3'd1 && t_state <= 3'd5)); // R2
    AST_STATE_STEP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (t_state == 3'd1 || t_state == $past(t_state) + 3'd1)); // R2
    AST_FETCH_LEN: assert property (@(posedge clk) disable iff (rst) (insn_end && cyc_type == K_FETCH) |-> t_state == 3'd4); // R3
    AST_WR_PLACE: assert property (@(posedge clk) disable iff (rst) wr_stb |-> (t_state == 3'd2 && (cyc_type == K_MWR || cyc_type == K_OUT))); // R9
    AST_RD_PLACE: assert property (@(posedge clk) disable iff (rst) rd_stb |-> ((t_state == 3'd2 || t_state == 3'd3) && (cyc_type == K_FETCH || cyc_type == K_MRD || cyc_type == K_IN))); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(rd_stb && wr_stb)); // R9
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) (t_state == 3'd1 || t_state == 3'd2) |=> $stable(bus_addr)); // R10
    AST_PORT_MIRROR: assert property (@(posedge clk) disable iff (rst) (cyc_type == K_IN || cyc_type == K_OUT) |-> bus_addr[15:8] == bus_addr[7:0]); // R7
    AST_NEXT_FETCH: assert property (@(posedge clk) disable iff (rst) insn_end |=> (cyc_type == K_FETCH && t_state == 3'd1)); // R12
endmodule

bind cpu_bus_seq cpu_bus_seq_chk #(.RESET_PC(RESET_PC)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .cyc_type (cyc_type),
    .t_state  (t_state),
    .bus_addr (bus_addr),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .insn_end (insn_end)
);

// File: tb/cpu_bus_seq_tb_top.sv
module cpu_bus_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_rdata, reg_h, reg_l, src_data, bus_wdata, acc_q;
    logic [2:0]  src_sel, cyc_type, t_state;
    logic [15:0] bus_addr;
    logic        rd_stb, wr_stb, insn_end;

    logic [7:0]  mem [0:255];
    logic [7:0]  gpr [0:7];
    int          n_chk = 0;
    int          n_err = 0;
    logic [15:0] m_pc;
    logic [7:0]  m_acc;

    always #5 clk = ~clk;

    assign bus_rdata = (cyc_type == 3'd3) ? (bus_addr[7:0] ^ 8'h5A) : mem[bus_addr[7:0]];
    assign src_data  = gpr[src_sel];

    cpu_bus_seq dut_i (
        .clk(clk), .rst(rst), .bus_rdata(bus_rdata), .reg_h(reg_h), .reg_l(reg_l),
        .src_data(src_data), .src_sel(src_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .cyc_type(cyc_type), .t_state(t_state),
        .insn_end(insn_end), .acc_q(acc_q)
    );

    function automatic int classify(input logic [7:0] op);
        if (op == 8'h86) return 2;
        if (op[7:3] == 5'b10000) return 1;
        if (op == 8'h22) return 3;
        if (op == 8'hDB) return 4;
        if (op == 8'hD3) return 5;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic st(input logic [2:0] c, input int t, input logic [15:0] a, input bit rd,
                      input bit wr, input bit e, input logic [7:0] wd, input bit cw, input string req);
        logic [32:0] act, exp;
        act = {cyc_type, t_state, bus_addr, rd_stb, wr_stb, insn_end, bus_wdata};
        exp = {c, t[2:0], a, rd, wr, e, (cw ? wd : bus_wdata)};
        check(act === exp, req, 64'(act), 64'(exp));
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_insn();
        logic [7:0]  op, b1, b2;
        logic [15:0] wz;
        int          kind;
        string       rq;
        reg_h = 8'($urandom);
        reg_l = 8'($urandom);
        op    = mem[m_pc[7:0]];
        kind  = classify(op);
        case (kind)
            1: rq = "R4 add-register";
            2: rq = "R5 add-memory";
            3: rq = "R6 store-hl";
            4: rq = "R7 port-in";
            5: rq = "R8 port-out";
            default: rq = "R11 unsupported";
        endcase
        for (int t = 1; t <= 4; t++) begin
            if (t == 4 && kind == 1)
                check(src_sel == op[2:0], "R4 src_sel", 64'(src_sel), 64'(op[2:0]));
            st(3'd0, t, (t == 4) ? m_pc + 16'd1 : m_pc, (t == 2 || t == 3), 1'b0,
               (t == 4) && (kind <= 1), 8'h00, 1'b0, "R3 R12 fetch");
        end
        m_pc = m_pc + 16'd1;
        if (kind == 1) m_acc = m_acc + gpr[op[2:0]];
        if (kind == 2) begin
            for (int t = 1; t <= 3; t++)
                st(3'd1, t, {reg_h, reg_l}, t >= 2, 1'b0, t == 3, 8'h00, 1'b0, rq);
            m_acc = m_acc + mem[reg_l];
        end else if (kind == 3) begin
            b1 = mem[m_pc[7:0]];
            for (int t = 1; t <= 3; t++) st(3'd1, t, m_pc, t >= 2, 1'b0, 1'b0, 8'h00, 1'b0, rq);
            m_pc = m_pc + 16'd1;
            b2 = mem[m_pc[7:0]];
            for (int t = 1; t <= 3; t++) st(3'd1, t, m_pc, t >= 2, 1'b0, 1'b0, 8'h00, 1'b0, rq);
            m_pc = m_pc + 16'd1;
            wz = {b2, b1};
            for (int t = 1; t <= 3; t++) st(3'd2, t, wz, 1'b0, t == 2, 1'b0, reg_l, t == 2, rq);
            wz = wz + 16'd1;
            for (int t = 1; t <= 3; t++) st(3'd2, t, wz, 1'b0, t == 2, t == 3, reg_h, t == 2, rq);
        end else if (kind == 4 || kind == 5) begin
            b1 = mem[m_pc[7:0]];
            for (int t = 1; t <= 3; t++) st(3'd1, t, m_pc, t >= 2, 1'b0, 1'b0, 8'h00, 1'b0, rq);
            m_pc = m_pc + 16'd1;
            if (kind == 4) begin
                for (int t = 1; t <= 3; t++) st(3'd3, t, {b1, b1}, t >= 2, 1'b0, t == 3, 8'h00, 1'b0, rq);
                m_acc = b1 ^ 8'h5A;
            end else begin
                for (int t = 1; t <= 3; t++) st(3'd4, t, {b1, b1}, 1'b0, t == 2, t == 3, m_acc, t == 2, rq);
            end
        end
        check(acc_q == m_acc, {rq, " accumulator"}, 64'(acc_q), 64'(m_acc));
    endtask

    initial begin
        int p;
        int k;
        logic [7:0] b;
        void'($urandom(32'd5150));
        reg_h = 8'h00;
        reg_l = 8'h00;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) gpr[i] = 8'($urandom);
        gpr[0] = 8'h7F;
        p = 0;
        // directed corners: port FF in, wrap add, W:Z carry across byte, port 00 out, no-ops
        mem[p] = 8'hDB; mem[p+1] = 8'hFF; p += 2;
        mem[p] = 8'h80; p += 1;
        mem[p] = 8'h22; mem[p+1] = 8'hFF; mem[p+2] = 8'h12; p += 3;
        mem[p] = 8'hD3; mem[p+1] = 8'h00; p += 2;
        mem[p] = 8'h76; p += 1;
        mem[p] = 8'hC3; p += 1;
        mem[p] = 8'h86; p += 1;
        while (p < 240) begin
            k = int'($urandom % 6);
            case (k)
                0: begin
                    do b = 8'($urandom); while (classify(b) != 0);
                    mem[p] = b; p += 1;
                end
                1: begin mem[p] = {5'b10000, 3'($urandom)}; p += 1; end
                2: begin mem[p] = 8'h86; p += 1; end
                3: begin mem[p] = 8'h22; mem[p+1] = 8'($urandom); mem[p+2] = 8'($urandom); p += 3; end
                4: begin mem[p] = 8'hDB; mem[p+1] = 8'($urandom); p += 2; end
                default: begin mem[p] = 8'hD3; mem[p+1] = 8'($urandom); p += 2; end
            endcase
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check({cyc_type, t_state, bus_addr, insn_end, acc_q} === {3'd0, 3'd1, 16'h0000, 1'b0, 8'h00},
              "R1 reset state", 64'({cyc_type, t_state, bus_addr, insn_end, acc_q}),
              64'({3'd0, 3'd1, 16'h0000, 1'b0, 8'h00}));
        m_pc  = 16'h0000;
        m_acc = 8'h00;
        while (m_pc < 16'(p)) do_insn();
        @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check({cyc_type, t_state, bus_addr, insn_end, acc_q} === {3'd0, 3'd1, 16'h0000, 1'b0, 8'h00},
              "R1 mid-instruction reset", 64'({cyc_type, t_state, bus_addr, insn_end, acc_q}),
              64'({3'd0, 3'd1, 16'h0000, 1'b0, 8'h00}));
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule